// File: doc/BRIEF.md
# GPIO Controller with Interrupt-Capable Pin Window

This block is a memory-mapped general-purpose I/O controller on a small 32-bit register bus. Software writes a whole register at a time, and reads return data in the same cycle. The block holds one output value and one output enable per pin, and it presents the input pins through a two-stage synchroniser.

A contiguous window of pins can be turned into interrupt sources. Interrupt index n is pin n plus a base offset, which is 8 by default. A select register gives every pin a two-bit field, and the low bit of that field chooses interrupt mode. A level register holds one polarity bit per interrupt index. Each selected source leaves the block as an active-high line toward a parent interrupt controller. Active-low sources are inverted on the way out.

Edge capture, masking and end-of-interrupt handling belong to the parent controller. Defaults are 22 pins and 6 interrupt sources starting at pin 8.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero, and `irq_out` is zero.
- R2: A write to the output data register (byte offset 0x2A0) stores the whole value. For every pin whose enable bit is 1, `pad_out` carries the stored bit and `pad_oe` is 1.
- R3: A pin whose output enable bit (register at offset 0x29C) is 0 is released: its `pad_oe` is 0 and its `pad_out` is 0, whatever value the output data register holds.
- R4: The input data register (offset 0x2A4) shows `pin_in` after two rising clock edges. One edge after a change, it still shows the previous value.
- R5: Interrupt n (n from 0 to IRQ_COUNT-1) follows pin IRQ_BASE+n only while bit 2*(IRQ_BASE+n) of the select register (offset 0x294) is 1. While that bit is 0, `irq_out[n]` is 0.
- R6: Bit n of the level register (offset 0x290) sets the polarity of interrupt n. With the bit at 1, `irq_out[n]` is high while the synchronised pin is 1. With the bit at 0, `irq_out[n]` is high while the pin is 0.
- R7: Unimplemented bits read as zero and ignore writes. These are the output enable and output data bits at or above PIN_COUNT, the level bits at or above IRQ_COUNT, and every select bit except 2*(IRQ_BASE+n). Setting only the odd bit of a pin's select field leaves the interrupt off.
- R8: Reads of any other offset return zero. Writes to any other offset change no register.
- R9: Every write replaces the full register value, so a write of a smaller value clears the bits that were set before.
- R10: The input data register is read-only, and writes to it leave its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pad_out | output | PIN_COUNT | Output value, zero where released |
| pad_oe | output | PIN_COUNT | Drive enable per pin |
| irq_out | output | IRQ_COUNT | Active-high interrupt lines to the parent controller |

## Verification
Each register, if stored wrongly, shows up on the read bus in the cycle after the write. The output and enable registers also appear on `pad_out` and `pad_oe` within that same cycle. A fault in the synchroniser changes the cycle in which a pin change first appears: one edge too early or too late is visible both in the input register and on `irq_out`. A fault in the select bit position, the window offset or the polarity inversion drives the wrong `irq_out` bit in the sweep over every index, polarity, select state and pin level. It shows two edges after the pin is driven.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam logic [11:0] OFS_LEVEL  = 12'h290;
   localparam logic [11:0] OFS_SELECT = 12'h294;
   localparam logic [11:0] OFS_OE     = 12'h29C;
   localparam logic [11:0] OFS_OUT    = 12'h2A0;
   localparam logic [11:0] OFS_IN     = 12'h2A4;

   typedef enum logic [2:0] {
      REG_NONE,
      REG_LEVEL,
      REG_SELECT,
      REG_OE,
      REG_OUT,
      REG_IN
   } reg_sel_e;

   function automatic reg_sel_e decode_offset(input logic [11:0] a);
      case (a)
         OFS_LEVEL:  return REG_LEVEL;
         OFS_SELECT: return REG_SELECT;
         OFS_OE:     return REG_OE;
         OFS_OUT:    return REG_OUT;
         OFS_IN:     return REG_IN;
         default:    return REG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   logic [WIDTH-1:0] stage1_q, stage2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else begin
         stage1_q <= d_in;
         stage2_q <= stage1_q;
      end
   end

   assign q_out = stage2_q;

   // counts edges since reset so the latency check never looks into reset
   logic [1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               warm_q <= 2'd0;
      else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
   end

   assert_two_edge_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (q_out == $past(d_in, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_irq_pkg::*;
#(
   parameter int PIN_COUNT = 22,
   parameter int IRQ_COUNT = 6,
   parameter int IRQ_BASE  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [11:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_we,
   output logic [31:0]          bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_sync,
   output logic [PIN_COUNT-1:0] oe_q,
   output logic [PIN_COUNT-1:0] out_q,
   output logic [IRQ_COUNT-1:0] lvl_q,
   output logic [IRQ_COUNT-1:0] sel_q
);
   reg_sel_e wr_sel, rd_sel;
   logic [31:0] sel_view;

   assign wr_sel = decode_offset(bus_addr);
   assign rd_sel = wr_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= '0;
         out_q <= '0;
         lvl_q <= '0;
         sel_q <= '0;
      end else if (bus_we) begin
         case (wr_sel)
            REG_OE:    oe_q  <= bus_wdata[PIN_COUNT-1:0];
            REG_OUT:   out_q <= bus_wdata[PIN_COUNT-1:0];
            REG_LEVEL: lvl_q <= bus_wdata[IRQ_COUNT-1:0];
            REG_SELECT:
               for (int n = 0; n < IRQ_COUNT; n++)
                  sel_q[n] <= bus_wdata[2*(IRQ_BASE+n)];
            default: ;
         endcase
      end
   end

   // place each stored select bit at the low bit of its pin's field
   generate
      for (genvar b = 0; b < 32; b++) begin : g_selview
         if ((b % 2 == 0) && (b / 2 >= IRQ_BASE) && (b / 2 < IRQ_BASE + IRQ_COUNT)) begin : g_live
            assign sel_view[b] = sel_q[b/2 - IRQ_BASE];
         end else begin : g_zero
            assign sel_view[b] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (rd_sel)
         REG_OE:     bus_rdata[PIN_COUNT-1:0] = oe_q;
         REG_OUT:    bus_rdata[PIN_COUNT-1:0] = out_q;
         REG_IN:     bus_rdata[PIN_COUNT-1:0] = pin_sync;
         REG_LEVEL:  bus_rdata[IRQ_COUNT-1:0] = lvl_q;
         REG_SELECT: bus_rdata = sel_view;
         default:    bus_rdata = '0;
      endcase
   end

   assert_full_replace_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && wr_sel == REG_OUT) |=> (out_q == $past(bus_wdata[PIN_COUNT-1:0])));

   assert_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (wr_sel == REG_NONE || wr_sel == REG_IN)) |=>
         ($stable(oe_q) && $stable(out_q) && $stable(lvl_q) && $stable(sel_q)));

endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
   parameter int PIN_COUNT = 22,
   parameter int IRQ_COUNT = 6,
   parameter int IRQ_BASE  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] pin_sync,
   input  logic [IRQ_COUNT-1:0] sel,
   input  logic [IRQ_COUNT-1:0] lvl,
   output logic [IRQ_COUNT-1:0] irq_o
);
   generate
      for (genvar n = 0; n < IRQ_COUNT; n++) begin : g_src
         logic asserted;
         // level 1: pin high is active; level 0: pin low is active
         assign asserted = lvl[n] ? pin_sync[IRQ_BASE+n] : ~pin_sync[IRQ_BASE+n];
         assign irq_o[n] = sel[n] & asserted;

         assert_unselected_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[n] |-> !irq_o[n]);

         assert_active_low_inverted_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[n] && !lvl[n] && !pin_sync[IRQ_BASE+n]) |-> irq_o[n]);
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
   parameter int PIN_COUNT = 22,
   parameter int IRQ_COUNT = 6,
   parameter int IRQ_BASE  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [11:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_we,
   output logic [31:0]          bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pad_out,
   output logic [PIN_COUNT-1:0] pad_oe,
   output logic [IRQ_COUNT-1:0] irq_out
);
   localparam int LAST_SEL_BIT = 2 * (IRQ_BASE + IRQ_COUNT - 1);

   generate
      if (PIN_COUNT < 1 || PIN_COUNT > 32) begin : g_bad_pins
         $error("PIN_COUNT must lie in 1..32");
      end
      if (IRQ_COUNT < 1 || IRQ_BASE < 0 || IRQ_BASE + IRQ_COUNT > PIN_COUNT) begin : g_bad_window
         $error("interrupt window must fit inside the pins");
      end
      if (LAST_SEL_BIT > 31) begin : g_bad_select
         $error("select field of the last interrupt pin lies beyond bit 31");
      end
   endgenerate

   logic [PIN_COUNT-1:0] pin_sync;
   logic [PIN_COUNT-1:0] oe_q, out_q;
   logic [IRQ_COUNT-1:0] lvl_q, sel_q;

   gpio_sync #(.WIDTH(PIN_COUNT)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_sync)
   );

   gpio_regs #(.PIN_COUNT(PIN_COUNT), .IRQ_COUNT(IRQ_COUNT), .IRQ_BASE(IRQ_BASE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .pin_sync  (pin_sync),
      .oe_q      (oe_q),
      .out_q     (out_q),
      .lvl_q     (lvl_q),
      .sel_q     (sel_q)
   );

   gpio_irq_map #(.PIN_COUNT(PIN_COUNT), .IRQ_COUNT(IRQ_COUNT), .IRQ_BASE(IRQ_BASE)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync),
      .sel      (sel_q),
      .lvl      (lvl_q),
      .irq_o    (irq_out)
   );

   assign pad_oe  = oe_q;
   assign pad_out = out_q & oe_q;

   assert_released_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0);

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
   localparam int PINS = 22;
   localparam int IRQS = 6;
   localparam int BASE = 8;
   localparam logic [31:0] PMASK = 32'h003F_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic [PINS-1:0] pin_in = '0;
   logic [PINS-1:0] pad_out, pad_oe;
   logic [IRQS-1:0] irq_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_ctrl #(.PIN_COUNT(PINS), .IRQ_COUNT(IRQS), .IRQ_BASE(BASE)) i_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] pat [4];
      pat[0] = 32'h0015_5AA5; pat[1] = 32'hFFFF_FFFF; pat[2] = 32'h002A_A55A; pat[3] = 32'h0000_0001;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd("R1", 12'h290, 0); rd("R1", 12'h294, 0); rd("R1", 12'h29C, 0);
      rd("R1", 12'h2A0, 0); rd("R1", 12'h2A4, 0);
      chk("R1", {10'd0, pad_oe}, 0); chk("R1", {10'd0, pad_out}, 0); chk("R1", {26'd0, irq_out}, 0);

      // R2 / R3 output and enable patterns
      for (int i = 0; i < 4; i++) begin
         logic [31:0] oe_v, out_v;
         oe_v = pat[i]; out_v = pat[(i + 1) % 4];
         wr(12'h29C, oe_v);
         wr(12'h2A0, out_v);
         rd("R2", 12'h2A0, out_v & PMASK);
         chk("R2", {10'd0, pad_oe}, oe_v & PMASK);
         chk("R3", {10'd0, pad_out}, out_v & oe_v & PMASK);
      end
      wr(12'h29C, 32'h0);
      chk("R3", {10'd0, pad_out}, 0);

      // R7 unimplemented bits
      wr(12'h29C, 32'hFFFF_FFFF); rd("R7", 12'h29C, PMASK);
      wr(12'h290, 32'hFFFF_FFFF); rd("R7", 12'h290, 32'h0000_003F);
      wr(12'h294, 32'hFFFF_FFFF); rd("R7", 12'h294, 32'h0555_0000);
      wr(12'h294, 32'hAAAA_AAAA); rd("R7", 12'h294, 0);
      pin_in = '1;
      repeat (2) @(negedge clk);
      chk("R7", {26'd0, irq_out}, 0);

      // R9 full replacement
      wr(12'h29C, 32'h0000_00FF); wr(12'h29C, 32'h0000_000F);
      rd("R9", 12'h29C, 32'h0000_000F);
      wr(12'h290, 32'h0); rd("R9", 12'h290, 0);

      // R4 two-edge input latency
      for (int i = 0; i < 4; i++) begin
         logic [31:0] prev;
         prev = {10'd0, pin_in};
         @(negedge clk);
         pin_in = pat[i][PINS-1:0] ^ 22'h15;
         @(negedge clk);
         rd("R4", 12'h2A4, prev);
         @(negedge clk);
         rd("R4", 12'h2A4, {10'd0, pin_in});
      end

      // R10 input register read-only
      wr(12'h2A4, 32'h0);
      rd("R10", 12'h2A4, {10'd0, pin_in});

      // R5 / R6 sweep over index, polarity, select and pin level
      for (int n = 0; n < IRQS; n++)
         for (int l = 0; l < 2; l++)
            for (int s = 0; s < 2; s++)
               for (int p = 0; p < 2; p++) begin
                  logic [31:0] exp;
                  wr(12'h290, 32'(l) << n);
                  wr(12'h294, 32'(s) << (2 * (BASE + n)));
                  pin_in = PINS'(p) << (BASE + n);
                  repeat (2) @(negedge clk);
                  exp = (s == 1 && p == l) ? (32'd1 << n) : 32'd0;
                  chk(l == 1 ? "R6" : "R5", {26'd0, irq_out}, exp);
               end

      // R8 undefined offsets
      wr(12'h29C, 32'h0000_1234);
      wr(12'h298, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF); wr(12'h2A8, 32'hFFFF_FFFF);
      rd("R8", 12'h298, 0); rd("R8", 12'h000, 0); rd("R8", 12'h2A8, 0); rd("R8", 12'h291, 0);
      rd("R8", 12'h29C, 32'h0000_1234);
      rd("R8", 12'h290, 32'h0000_0020);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule